// File: doc/BRIEF.md
# Early Branch Resolution Unit

This unit settles conditional branches while the branch is still in the decode stage of a five-stage in-order pipeline. The pipeline stages are fetch, decode, execute, memory and writeback. The unit has its own comparator and does not use the execute-stage ALU. It supports three branch kinds. Two of them test one register against zero (taken on zero, or taken on non-zero). The third compares two registers and is taken when they are equal. Operands come from the register file, or they are forwarded from the memory-stage ALU result or the writeback value.

When a needed value is still being produced, the unit raises a stall request. This happens when an instruction in execute will write the register, or when a load in the memory stage will write it. The front end fetches along the predicted path. When the resolved direction differs from the prediction, the unit signals a redirect in that same cycle, together with the correct next PC. In the following cycle it raises a single-cycle flush that kills the wrong-path instruction now held in the fetch/decode register.

The surrounding datapath drives the ports each cycle: the decode-stage branch fields, the register file read values, and the destination, write-enable and load flags of the later stages. The fetch logic uses `stall`, `redirect` and `redirect_pc`. The fetch/decode register uses `flush`.

Top module: `early_branch_unit`

## Requirements
- R1: A branch with `id_kind` 2'b01 (zero test) is taken when its first operand equals zero. A branch with `id_kind` 2'b10 (non-zero test) is taken when that operand is non-zero. `id_kind` 2'b00 means no branch.
- R2: A branch with `id_kind` 2'b11 is taken when its first and second operands are equal.
- R3: The taken target is `id_pc` + 4 + (sign-extended `id_offset` shifted left by two). The not-taken next PC is `id_pc` + 4.
- R4: An operand is resolved in this priority order. First, the memory-stage ALU result, if that stage holds a valid non-load that writes the register. Second, the writeback value, if writeback writes the register. Otherwise, the register file value. Register 0 is never forwarded.
- R5: A live branch stalls while a valid, writing instruction in execute targets a register the branch reads. This holds for both ALU operations and loads, and it does not depend on any later stage.
- R6: A live branch stalls while a valid load in the memory stage targets a register the branch reads. Once that load reaches writeback, its value is forwarded and the stall ends.
- R7: Only registers that the branch actually reads can cause a stall. The zero and non-zero tests never read `id_rt`. Register 0 never stalls. Non-writing or invalid producers are ignored. No stall is raised without a live branch.
- R8: A live, unstalled branch whose resolved direction differs from `id_pred_taken` asserts `redirect` in the same cycle. In that cycle, `redirect_pc` is the target if the branch is taken and PC+4 if it is not. A branch whose direction matches the prediction does not redirect.
- R9: `flush` is high for exactly the one cycle after each redirect, and at no other time.
- R10: While `flush` is high, the instruction in decode is treated as squashed: it causes neither a stall nor a redirect.
- R11: While `rst_n` is low, and right after reset is released, `flush` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode stage holds a valid instruction |
| id_kind | input | 2 | Branch kind: 00 none, 01 zero test, 10 non-zero test, 11 equal |
| id_rs | input | 5 | First source register of the branch |
| id_rt | input | 5 | Second source register (equal compare only) |
| id_pc | input | 32 | PC of the branch |
| id_offset | input | 16 | Signed word offset of the branch |
| id_pred_taken | input | 1 | Direction the front end followed |
| rf_rs_data | input | 32 | Register file value for `id_rs` |
| rf_rt_data | input | 32 | Register file value for `id_rt` |
| ex_valid | input | 1 | Execute stage holds a valid instruction |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_rd | input | 5 | Execute-stage destination |
| mem_valid | input | 1 | Memory stage holds a valid instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_rd | input | 5 | Memory-stage destination |
| mem_alu_res | input | 32 | Memory-stage ALU result |
| wb_valid | input | 1 | Writeback stage holds a valid instruction |
| wb_we | input | 1 | Writeback instruction writes a register |
| wb_rd | input | 5 | Writeback destination |
| wb_data | input | 32 | Value being written back |
| stall | output | 1 | Hold decode and fetch this cycle |
| redirect | output | 1 | Misprediction: fetch must restart at `redirect_pc` |
| redirect_pc | output | 32 | Correct next PC of the branch in decode |
| flush | output | 1 | Squash the fetch/decode register content this cycle |

## Verification
The bench builds the unit with its default widths: 32-bit data and PC, 5-bit register numbers and a 16-bit offset. With these widths the sign-extension boundary of the offset sits at bit 15, so both a negative and a positive offset produce target values the bench can compute exactly. Directed sequences walk a producer from execute through memory to writeback. They cover the two-cycle load stall, the one-cycle ALU stall, the forwarding priority and the register-0 exclusion. A randomized phase then confines register numbers to 0 through 3 and mostly-zero operand values. This makes dependency collisions, zero tests and back-to-back mispredictions inside the flush cycle frequent.

// File: rtl/ebu_pkg.sv
package ebu_pkg;

    typedef enum logic [1:0] {
        BR_NONE = 2'b00,
        BR_EQZ  = 2'b01,
        BR_NEZ  = 2'b10,
        BR_EQ   = 2'b11
    } br_kind_e;

    typedef struct packed {
        logic flush;
    } ebu_state_t;

endpackage

// File: rtl/ebu_operand_fwd.sv
module ebu_operand_fwd #(
    parameter int XLEN = 32,
    parameter int RA_W = 5
) (
    input  logic [RA_W-1:0] sel,
    input  logic [XLEN-1:0] file_val,
    input  logic            mem_valid,
    input  logic            mem_we,
    input  logic            mem_is_load,
    input  logic [RA_W-1:0] mem_rd,
    input  logic [XLEN-1:0] mem_val,
    input  logic            wb_valid,
    input  logic            wb_we,
    input  logic [RA_W-1:0] wb_rd,
    input  logic [XLEN-1:0] wb_val,
    output logic [XLEN-1:0] val
);
    logic nonzero;
    logic mem_hit;
    logic wb_hit;

    always_comb begin
        nonzero = (sel != '0);
        mem_hit = nonzero && mem_valid && mem_we && !mem_is_load && (mem_rd == sel);
        wb_hit  = nonzero && wb_valid && wb_we && (wb_rd == sel);
        if (mem_hit) begin
            val = mem_val;
        end else if (wb_hit) begin
            val = wb_val;
        end else begin
            val = file_val;
        end
    end
endmodule

// File: rtl/ebu_hazard.sv
module ebu_hazard #(
    parameter int RA_W  = 5,
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0]           need,
    input  logic [N_SRC-1:0][RA_W-1:0] src,
    input  logic                       ex_valid,
    input  logic                       ex_we,
    input  logic [RA_W-1:0]            ex_rd,
    input  logic                       mem_valid,
    input  logic                       mem_we,
    input  logic                       mem_is_load,
    input  logic [RA_W-1:0]            mem_rd,
    output logic                       stall
);
    logic [N_SRC-1:0] blocked;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic ex_dep;
        logic ld_dep;
        always_comb begin
            ex_dep     = ex_valid && ex_we && (ex_rd == src[i]);
            ld_dep     = mem_valid && mem_we && mem_is_load && (mem_rd == src[i]);
            blocked[i] = need[i] && (src[i] != '0) && (ex_dep || ld_dep);
        end
    end

    assign stall = |blocked;
endmodule

// File: rtl/ebu_cond_eval.sv
module ebu_cond_eval #(
    parameter int XLEN = 32
) (
    input  ebu_pkg::br_kind_e kind,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic              taken
);
    import ebu_pkg::*;

    logic a_zero;
    logic same;

    always_comb begin
        a_zero = (a == '0);
        same   = (a == b);
        unique case (kind)
            BR_EQZ:  taken = a_zero;
            BR_NEZ:  taken = !a_zero;
            BR_EQ:   taken = same;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/early_branch_unit.sv
module early_branch_unit #(
    parameter int XLEN  = 32,
    parameter int RA_W  = 5,
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_valid,
    input  logic [1:0]       id_kind,
    input  logic [RA_W-1:0]  id_rs,
    input  logic [RA_W-1:0]  id_rt,
    input  logic [XLEN-1:0]  id_pc,
    input  logic [OFF_W-1:0] id_offset,
    input  logic             id_pred_taken,
    input  logic [XLEN-1:0]  rf_rs_data,
    input  logic [XLEN-1:0]  rf_rt_data,
    input  logic             ex_valid,
    input  logic             ex_we,
    input  logic [RA_W-1:0]  ex_rd,
    input  logic             mem_valid,
    input  logic             mem_we,
    input  logic             mem_is_load,
    input  logic [RA_W-1:0]  mem_rd,
    input  logic [XLEN-1:0]  mem_alu_res,
    input  logic             wb_valid,
    input  logic             wb_we,
    input  logic [RA_W-1:0]  wb_rd,
    input  logic [XLEN-1:0]  wb_data,
    output logic             stall,
    output logic             redirect,
    output logic [XLEN-1:0]  redirect_pc,
    output logic             flush
);
    import ebu_pkg::*;

    localparam int N_SRC = 2;
    localparam int EXT_W = XLEN - OFF_W - 2;

    ebu_state_t st_d;
    ebu_state_t st_q;

    br_kind_e                   kind;
    logic                       live;
    logic [N_SRC-1:0]           need;
    logic [N_SRC-1:0][RA_W-1:0] src;
    logic [N_SRC-1:0][XLEN-1:0] file_vals;
    logic [N_SRC-1:0][XLEN-1:0] opnd;
    logic                       hz_stall;
    logic                       taken;
    logic [XLEN-1:0]            seq_pc;
    logic [XLEN-1:0]            tgt_pc;

    always_comb begin
        kind         = br_kind_e'(id_kind);
        live         = id_valid && (kind != BR_NONE) && !st_q.flush;
        need[0]      = live;
        need[1]      = live && (kind == BR_EQ);
        src[0]       = id_rs;
        src[1]       = id_rt;
        file_vals[0] = rf_rs_data;
        file_vals[1] = rf_rt_data;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_fwd
        ebu_operand_fwd #(
            .XLEN (XLEN),
            .RA_W (RA_W)
        ) u_fwd (
            .sel         (src[i]),
            .file_val    (file_vals[i]),
            .mem_valid   (mem_valid),
            .mem_we      (mem_we),
            .mem_is_load (mem_is_load),
            .mem_rd      (mem_rd),
            .mem_val     (mem_alu_res),
            .wb_valid    (wb_valid),
            .wb_we       (wb_we),
            .wb_rd       (wb_rd),
            .wb_val      (wb_data),
            .val         (opnd[i])
        );
    end

    ebu_hazard #(
        .RA_W  (RA_W),
        .N_SRC (N_SRC)
    ) u_hazard (
        .need        (need),
        .src         (src),
        .ex_valid    (ex_valid),
        .ex_we       (ex_we),
        .ex_rd       (ex_rd),
        .mem_valid   (mem_valid),
        .mem_we      (mem_we),
        .mem_is_load (mem_is_load),
        .mem_rd      (mem_rd),
        .stall       (hz_stall)
    );

    ebu_cond_eval #(
        .XLEN (XLEN)
    ) u_cond (
        .kind  (kind),
        .a     (opnd[0]),
        .b     (opnd[1]),
        .taken (taken)
    );

    // Next-PC select and redirect decision; flush is registered from it.
    always_comb begin
        st_d        = st_q;
        seq_pc      = id_pc + XLEN'(4);
        tgt_pc      = seq_pc + {{EXT_W{id_offset[OFF_W-1]}}, id_offset, 2'b00};
        redirect_pc = taken ? tgt_pc : seq_pc;
        stall       = hz_stall;
        redirect    = live && !hz_stall && (taken != id_pred_taken);
        st_d.flush  = redirect;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flush = st_q.flush;
endmodule

// File: rtl/early_branch_unit_chk.sv
module early_branch_unit_chk #(
    parameter int RA_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            id_valid,
    input logic [1:0]      id_kind,
    input logic [RA_W-1:0] id_rs,
    input logic            mem_valid,
    input logic            mem_we,
    input logic            mem_is_load,
    input logic [RA_W-1:0] mem_rd,
    input logic            stall,
    input logic            redirect,
    input logic            flush
);
    a_r9_flush_follows_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> flush);

    a_r9_flush_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    a_r10_no_redirect_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!redirect && !stall));

    a_r8_no_redirect_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !redirect);

    a_r8_redirect_needs_branch: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (id_valid && id_kind != 2'b00));

    a_r7_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_valid || id_kind == 2'b00) |-> !stall);

    a_r6_load_in_mem_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && id_kind != 2'b00 && !flush && id_rs != '0 &&
         mem_valid && mem_we && mem_is_load && mem_rd == id_rs) |-> stall);
endmodule

bind early_branch_unit early_branch_unit_chk #(.RA_W(RA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_valid    (id_valid),
    .id_kind     (id_kind),
    .id_rs       (id_rs),
    .mem_valid   (mem_valid),
    .mem_we      (mem_we),
    .mem_is_load (mem_is_load),
    .mem_rd      (mem_rd),
    .stall       (stall),
    .redirect    (redirect),
    .flush       (flush)
);

// File: tb/early_branch_unit_bench.sv
module early_branch_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        id_valid = 0;
    logic [1:0]  id_kind = 0;
    logic [4:0]  id_rs = 0, id_rt = 0;
    logic [31:0] id_pc = 0;
    logic [15:0] id_offset = 0;
    logic        id_pred_taken = 0;
    logic [31:0] rf_rs_data = 0, rf_rt_data = 0;
    logic        ex_valid = 0, ex_we = 0;
    logic [4:0]  ex_rd = 0;
    logic        mem_valid = 0, mem_we = 0, mem_is_load = 0;
    logic [4:0]  mem_rd = 0;
    logic [31:0] mem_alu_res = 0;
    logic        wb_valid = 0, wb_we = 0;
    logic [4:0]  wb_rd = 0;
    logic [31:0] wb_data = 0;
    logic        stall, redirect, flush;
    logic [31:0] redirect_pc;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    early_branch_unit u_early_branch_unit (.*);

    // ---------------- reference model ----------------
    logic        m_flush_q = 0;
    logic        m_live, m_stall, m_taken, m_redirect;
    logic [31:0] m_a, m_b, m_pc;
    int          m_off;

    function automatic logic [31:0] pick(input logic [4:0] r, input logic [31:0] fv);
        if (r == 0) return fv;
        if (mem_valid && mem_we && !mem_is_load && mem_rd == r) return mem_alu_res;
        if (wb_valid && wb_we && wb_rd == r) return wb_data;
        return fv;
    endfunction

    function automatic logic busy(input logic [4:0] r);
        if (r == 0) return 1'b0;
        if (ex_valid && ex_we && ex_rd == r) return 1'b1;
        return mem_valid && mem_we && mem_is_load && mem_rd == r;
    endfunction

    always_comb begin
        m_live  = id_valid && id_kind != 2'b00 && !m_flush_q;
        m_a     = pick(id_rs, rf_rs_data);
        m_b     = pick(id_rt, rf_rt_data);
        m_stall = m_live && (busy(id_rs) || (id_kind == 2'b11 && busy(id_rt)));
        case (id_kind)
            2'b01:   m_taken = (m_a == 0);
            2'b10:   m_taken = (m_a != 0);
            2'b11:   m_taken = (m_a == m_b);
            default: m_taken = 1'b0;
        endcase
        m_redirect = m_live && !m_stall && (m_taken != id_pred_taken);
        m_off      = $signed(id_offset);
        m_pc       = m_taken ? (id_pc + 32'd4 + 32'(m_off * 4)) : (id_pc + 32'd4);
    end

    always @(posedge clk) begin
        m_flush_q <= rst_n ? m_redirect : 1'b0;
        cycles    <= cycles + 1;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        chk("R5,R6,R7 stall vs model", 32'(stall), 32'(m_stall));
        chk("R8 redirect vs model", 32'(redirect), 32'(m_redirect));
        chk("R9 flush vs model", 32'(flush), 32'(m_flush_q));
        if (m_redirect) chk("R3 redirect_pc vs model", redirect_pc, m_pc);
    endtask

    task automatic quiet();
        id_valid = 0; id_kind = 0; id_rs = 0; id_rt = 0; id_pred_taken = 0;
        rf_rs_data = 0; rf_rt_data = 0;
        ex_valid = 0; ex_we = 0; ex_rd = 0;
        mem_valid = 0; mem_we = 0; mem_is_load = 0; mem_rd = 0; mem_alu_res = 0;
        wb_valid = 0; wb_we = 0; wb_rd = 0; wb_data = 0;
    endtask

    task automatic br(input logic [1:0] k, input logic [4:0] rs, input logic [4:0] rt,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] pc, input logic [15:0] off, input logic pred);
        id_valid = 1; id_kind = k; id_rs = rs; id_rt = rt;
        rf_rs_data = a; rf_rt_data = b; id_pc = pc; id_offset = off; id_pred_taken = pred;
    endtask

    task automatic settle();
        #2;
        compare_model();
    endtask

    task automatic next();
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        quiet();
        @(negedge clk);
        settle(); chk("R11 flush in reset", 32'(flush), 0);
        next();
        br(2'b01, 5'd5, 0, 0, 0, 32'h100, 16'd3, 1'b0);   // mispredicting, but in reset
        settle(); chk("R11 flush in reset", 32'(flush), 0);
        next();
        quiet();
        rst_n = 1;
        settle(); chk("R11 flush after reset", 32'(flush), 0);
        chk("R7 no stall when idle", 32'(stall), 0);
        next();

        // R1 zero test taken, predicted not taken -> redirect to target
        br(2'b01, 5'd5, 0, 32'd0, 0, 32'h100, 16'd3, 1'b0);
        settle();
        chk("R1 zero test redirect", 32'(redirect), 1);
        chk("R3 positive offset target", redirect_pc, 32'h110);
        next();
        // R9 flush the cycle after; R10 branch in decode ignored
        br(2'b01, 5'd5, 0, 32'd0, 0, 32'h200, 16'd1, 1'b0);
        ex_valid = 1; ex_we = 1; ex_rd = 5'd5;
        settle();
        chk("R9 flush after redirect", 32'(flush), 1);
        chk("R10 no redirect during flush", 32'(redirect), 0);
        chk("R10 no stall during flush", 32'(stall), 0);
        next();
        quiet();
        settle(); chk("R9 flush single cycle", 32'(flush), 0);
        next();

        // R1 non-zero test on zero, predicted taken -> redirect to PC+4
        br(2'b10, 5'd6, 0, 32'd0, 0, 32'h300, 16'd8, 1'b1);
        settle();
        chk("R1 non-zero test not taken", 32'(redirect), 1);
        chk("R8 not-taken next pc", redirect_pc, 32'h304);
        next(); quiet(); settle(); next();

        // R2 equal, predicted taken -> no redirect
        br(2'b11, 5'd1, 5'd2, 32'hABCD, 32'hABCD, 32'h400, 16'd4, 1'b1);
        settle(); chk("R2 equal matches prediction", 32'(redirect), 0);
        next();
        // R2 unequal, predicted taken -> redirect PC+4
        br(2'b11, 5'd1, 5'd2, 32'hABCD, 32'hABCE, 32'h400, 16'd4, 1'b1);
        settle();
        chk("R2 unequal redirect", 32'(redirect), 1);
        chk("R2 unequal next pc", redirect_pc, 32'h404);
        next(); quiet(); settle(); next();

        // R3 negative offset, zero test taken, predicted not taken
        br(2'b01, 5'd3, 0, 0, 0, 32'h1000, 16'hFFFE, 1'b0);
        settle(); chk("R3 negative offset target", redirect_pc, 32'hFFC);
        next(); quiet(); settle(); next();

        // R4 memory result beats writeback and file
        br(2'b01, 5'd7, 0, 32'd0, 0, 32'h500, 16'd2, 1'b1);
        mem_valid = 1; mem_we = 1; mem_rd = 5'd7; mem_alu_res = 32'd9;
        wb_valid = 1; wb_we = 1; wb_rd = 5'd7; wb_data = 32'd0;
        settle();
        chk("R4 memory priority -> not taken redirect", 32'(redirect), 1);
        chk("R4 memory priority pc", redirect_pc, 32'h504);
        next(); quiet(); settle(); next();
        // R4 writeback beats file
        br(2'b10, 5'd7, 0, 32'd0, 0, 32'h600, 16'd2, 1'b0);
        wb_valid = 1; wb_we = 1; wb_rd = 5'd7; wb_data = 32'd1;
        settle(); chk("R4 writeback forward", 32'(redirect), 1);
        next(); quiet(); settle(); next();
        // R4 register 0 never forwarded
        br(2'b01, 5'd0, 0, 32'd0, 0, 32'h700, 16'd2, 1'b1);
        mem_valid = 1; mem_we = 1; mem_rd = 5'd0; mem_alu_res = 32'd5;
        settle(); chk("R4 r0 not forwarded", 32'(redirect), 0);
        next(); quiet();

        // R5 ALU in execute: one stall, then forwarded from memory
        br(2'b10, 5'd4, 0, 32'd0, 0, 32'h800, 16'd1, 1'b1);
        ex_valid = 1; ex_we = 1; ex_rd = 5'd4;
        settle();
        chk("R5 ALU dep stall", 32'(stall), 1);
        chk("R5 no redirect while stalled", 32'(redirect), 0);
        next();
        ex_valid = 0;
        mem_valid = 1; mem_we = 1; mem_rd = 5'd4; mem_alu_res = 32'd0;
        settle();
        chk("R5 stall released", 32'(stall), 0);
        chk("R5 forwarded zero redirects", 32'(redirect), 1);
        next(); quiet(); settle(); next();

        // R6 load: execute, memory stall; writeback forwards
        br(2'b11, 5'd1, 5'd9, 32'd3, 32'd0, 32'h900, 16'd5, 1'b0);
        ex_valid = 1; ex_we = 1; ex_rd = 5'd9;
        settle(); chk("R6 load in execute stall", 32'(stall), 1);
        next();
        ex_valid = 0;
        mem_valid = 1; mem_we = 1; mem_is_load = 1; mem_rd = 5'd9; mem_alu_res = 32'd3;
        settle(); chk("R6 load in memory stall", 32'(stall), 1);
        next();
        mem_valid = 0; mem_is_load = 0;
        wb_valid = 1; wb_we = 1; wb_rd = 5'd9; wb_data = 32'd3;
        settle();
        chk("R6 load forwarded from writeback", 32'(stall), 0);
        chk("R6 equal after forward redirects", 32'(redirect), 1);
        chk("R6 target", redirect_pc, 32'h918);
        next(); quiet(); settle(); next();

        // R7 zero test ignores rt; r0 and non-writing producers ignored
        br(2'b01, 5'd2, 5'd8, 32'd1, 0, 32'hA00, 16'd1, 1'b0);
        ex_valid = 1; ex_we = 1; ex_rd = 5'd8;
        settle(); chk("R7 rt ignored for zero test", 32'(stall), 0);
        next();
        ex_rd = 5'd0; id_rs = 5'd0;
        settle(); chk("R7 r0 never stalls", 32'(stall), 0);
        next();
        id_rs = 5'd2; ex_rd = 5'd2; ex_we = 0;
        mem_valid = 1; mem_we = 0; mem_is_load = 1; mem_rd = 5'd2;
        settle(); chk("R7 non-writing producers ignored", 32'(stall), 0);
        next(); quiet(); settle(); next();

        // randomized phase with model comparison
        for (int n = 0; n < 3000; n++) begin
            id_valid      = ($urandom_range(0, 7) != 0);
            id_kind       = 2'($urandom_range(0, 3));
            id_rs         = 5'($urandom_range(0, 3));
            id_rt         = 5'($urandom_range(0, 3));
            id_pc         = {$urandom_range(0, 32'h3FFFFFF), 2'b00};
            id_offset     = 16'($urandom());
            id_pred_taken = 1'($urandom_range(0, 1));
            rf_rs_data    = ($urandom_range(0, 2) == 0) ? 32'd0 : 32'($urandom_range(0, 2));
            rf_rt_data    = 32'($urandom_range(0, 2));
            ex_valid      = 1'($urandom_range(0, 1));
            ex_we         = 1'($urandom_range(0, 1));
            ex_rd         = 5'($urandom_range(0, 3));
            mem_valid     = 1'($urandom_range(0, 1));
            mem_we        = 1'($urandom_range(0, 1));
            mem_is_load   = 1'($urandom_range(0, 1));
            mem_rd        = 5'($urandom_range(0, 3));
            mem_alu_res   = 32'($urandom_range(0, 2));
            wb_valid      = 1'($urandom_range(0, 1));
            wb_we         = 1'($urandom_range(0, 1));
            wb_rd         = 5'($urandom_range(0, 3));
            wb_data       = 32'($urandom_range(0, 2));
            settle();
            next();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule